// File: doc/BRIEF.md
# Exception Entry Context Stacker with Stack Limit Guard

This block performs the context-save part of exception entry. On a request, it takes the stack pointer and limit of the stack that was active when the exception arrived, either the main stack or the process stack. It then writes an eight-word frame of 32-bit words, one word per cycle, from the highest address down. The program status word goes in first at SP-4. The saved registers follow, and R0 lands at SP-32. The frame is checked against the active limit once, before any word is issued. If the frame does not fit, no word is written at all. The stack pointer is pinned at the limit, and a stack-overflow usage fault is entered in place of the requested exception.

A memory protection checker answers each write in the cycle the write is presented. If it reports a fault, the remaining writes are dropped and a memory-management fault is entered instead. Both substituted faults are derived exceptions: the original request is reported back as still pending. The handler is entered only after stacking ends, so every write happens under thread-level rules.

The block also watches direct thread writes to the active stack pointer. It flags a write whose value falls under the limit one cycle after the write. The flag depends on the written value alone and not on any later access. A sticky two-bit status register records overflow and stacking errors, and software clears its bits by writing ones.

Top module: `stack_entry_engine`

## Requirements
- R1: When a request fits, the first write appears one cycle after the request. One word is written per cycle for eight cycles, at addresses SP-4, SP-8, ..., SP-32. Frame word i is the slice `ctx_frame[32*i +: 32]`, and the words go out in the order 7 (status word) down to 0 (R0).
- R2: When `stack_sel` is 0, the block uses `msp` and `msp_lim`; when it is 1, it uses `psp` and `psp_lim`. `sp_upd_sel` echoes the stack that was used.
- R3: The frame does not fit when SP is under 32 or when SP-32 is under the limit, compared unsigned. In that case no write is issued. One cycle after the request, `entry_done` pulses with `entry_exc` equal to `USAGE_ID` (default 6), and `sp_upd_val` equals the limit.
- R4: No write is ever issued to an address under the active limit.
- R5: If `mem_prot_fault` is high during write k, no further write follows. In the next cycle, `entry_done` pulses with `entry_exc` equal to `MEMM_ID` (default 4), and `sp_upd_val` equals SP-32.
- R6: When all eight writes succeed, `entry_done` pulses one cycle after the last write, with the requested code and `sp_upd_val` equal to SP-32. A new request that arrives while `stacking_busy` is high is ignored.
- R7: A derived fault (R3 or R5) pulses `pend_valid` with `pend_exc` equal to the original code. A normal entry leaves `pend_valid` low.
- R8: `spw_ovf` pulses one cycle after `sp_wr_en` when `sp_wr_val` is under the active limit. A stack-pointer write made while stacking is in progress is ignored.
- R9: `fault_stat[0]` (overflow) is set by R3 or R8, and `fault_stat[1]` (stacking error) is set by R5. Each bit becomes visible two cycles after its cause and holds until software writes a one to it through `stat_clr`. If a set and a clear reach the same bit in the same cycle, the set wins.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request pulse |
| exc_id | input | 9 | Code of the requested exception |
| ctx_frame | input | 256 | Eight context words, word i in bits 32*i+31:32*i |
| stack_sel | input | 1 | Active stack: 0 main, 1 process |
| msp | input | 32 | Main stack pointer |
| psp | input | 32 | Process stack pointer |
| msp_lim | input | 32 | Main stack limit |
| psp_lim | input | 32 | Process stack limit |
| sp_wr_en | input | 1 | Thread write to the active stack pointer |
| sp_wr_val | input | 32 | Value being written |
| mem_prot_fault | input | 1 | Protection fault on the write presented this cycle |
| mem_wr_valid | output | 1 | Stacking write request |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 32 | Write data |
| stacking_busy | output | 1 | Stacking in progress |
| entry_done | output | 1 | Handler entry pulse |
| entry_exc | output | 9 | Exception actually taken |
| pend_valid | output | 1 | Original exception left pending |
| pend_exc | output | 9 | Code left pending |
| sp_upd_valid | output | 1 | Stack pointer update |
| sp_upd_sel | output | 1 | Stack being updated |
| sp_upd_val | output | 32 | New stack pointer value |
| spw_ovf | output | 1 | Direct stack pointer write went under the limit |
| stat_clr | input | 2 | Write-one-to-clear for fault_stat |
| fault_stat | output | 2 | Sticky flags: bit 0 overflow, bit 1 stacking error |

## Verification
Every result is tied to a fixed count of clock edges after its cause:
- When a request is accepted, the first write, or the overflow entry, appears one edge later.
- Write k appears k+1 edges after the request.
- Entry follows one edge after the last write, or one edge after a faulted write.
- `spw_ovf` rises one edge after the stack-pointer write.
- The sticky status follows one edge after those pulses.

The bench drives inputs and samples outputs on the falling edge. After each stimulus it advances exactly the number of falling edges that the counts above predict before it compares. The sweeps cover stack-pointer offsets around the frame boundary on both stacks, a protection fault at every write position, and stack-pointer writes around the limit.

// File: rtl/ses_pkg.sv
package ses_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_PUSH = 1'b1
  } seq_state_e;

  localparam int STAT_W      = 2;
  localparam int STAT_OVF    = 0;
  localparam int STAT_STKERR = 1;
endpackage

// File: rtl/ses_limit_cmp.sv
module ses_limit_cmp #(
  parameter int ADDR_W = 32,
  parameter int OFFSET = 0
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              below
);
  generate
    if (OFFSET == 0) begin : g_plain
      assign below = base < limit;
    end else begin : g_offset
      localparam logic [ADDR_W-1:0] OFF = ADDR_W'(OFFSET);
      logic [ADDR_W-1:0] low;
      assign low   = base - OFF;
      assign below = (base < OFF) || (low < limit);
    end
  endgenerate
endmodule

// File: rtl/ses_fault_status.sv
module ses_fault_status
  import ses_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_ovf,
  input  logic              set_err,
  input  logic [STAT_W-1:0] clr,
  output logic [STAT_W-1:0] stat
);
  logic [STAT_W-1:0] set_vec;

  always_comb begin
    set_vec              = '0;
    set_vec[STAT_OVF]    = set_ovf;
    set_vec[STAT_STKERR] = set_err;
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat & ~clr) | set_vec;
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    set_ovf |=> stat[STAT_OVF]);
  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr[STAT_STKERR] && !set_err) |=> !stat[STAT_STKERR]);
endmodule

// File: rtl/ses_push_seq.sv
module ses_push_seq
  import ses_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int EXC_W       = 9,
  parameter int FRAME_WORDS = 8,
  parameter int WORD_BYTES  = 4,
  parameter int USAGE_ID    = 6,
  parameter int MEMM_ID     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req,
  input  logic [EXC_W-1:0]              req_exc,
  input  logic                          req_sel,
  input  logic [ADDR_W-1:0]             sp_act,
  input  logic [ADDR_W-1:0]             lim_act,
  input  logic                          frame_ovf,
  input  logic [FRAME_WORDS*DATA_W-1:0] ctx,
  input  logic                          prot_fault,
  output logic                          wr_valid,
  output logic [ADDR_W-1:0]             wr_addr,
  output logic [DATA_W-1:0]             wr_data,
  output logic                          busy,
  output logic                          done,
  output logic [EXC_W-1:0]              done_exc,
  output logic                          pend_valid,
  output logic [EXC_W-1:0]              pend_exc,
  output logic                          spu_valid,
  output logic                          spu_sel,
  output logic [ADDR_W-1:0]             spu_val,
  output logic                          ovf_evt,
  output logic                          err_evt
);
  localparam int CNT_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] FRAME  = ADDR_W'(FRAME_WORDS * WORD_BYTES);
  localparam logic [CNT_W-1:0]  TOP    = CNT_W'(FRAME_WORDS - 1);

  seq_state_e                    state;
  logic [CNT_W-1:0]              cnt;
  logic [CNT_W-1:0]              cnt_nxt;
  logic [FRAME_WORDS*DATA_W-1:0] ctx_q;
  logic [ADDR_W-1:0]             sp_q;
  logic [ADDR_W-1:0]             lim_q;
  logic                          sel_q;
  logic [EXC_W-1:0]              exc_q;

  assign cnt_nxt = cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      cnt        <= '0;
      ctx_q      <= '0;
      sp_q       <= '0;
      lim_q      <= '0;
      sel_q      <= 1'b0;
      exc_q      <= '0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      done_exc   <= '0;
      pend_valid <= 1'b0;
      pend_exc   <= '0;
      spu_valid  <= 1'b0;
      spu_sel    <= 1'b0;
      spu_val    <= '0;
      ovf_evt    <= 1'b0;
      err_evt    <= 1'b0;
    end else begin
      done       <= 1'b0;
      pend_valid <= 1'b0;
      spu_valid  <= 1'b0;
      ovf_evt    <= 1'b0;
      err_evt    <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (req) begin
            if (frame_ovf) begin
              done       <= 1'b1;
              done_exc   <= EXC_W'(USAGE_ID);
              pend_valid <= 1'b1;
              pend_exc   <= req_exc;
              spu_valid  <= 1'b1;
              spu_sel    <= req_sel;
              spu_val    <= lim_act;
              ovf_evt    <= 1'b1;
            end else begin
              state    <= SEQ_PUSH;
              busy     <= 1'b1;
              ctx_q    <= ctx;
              sp_q     <= sp_act;
              lim_q    <= lim_act;
              sel_q    <= req_sel;
              exc_q    <= req_exc;
              cnt      <= TOP;
              wr_valid <= 1'b1;
              wr_addr  <= sp_act - STEP;
              wr_data  <= ctx[(FRAME_WORDS-1)*DATA_W +: DATA_W];
            end
          end
        end
        SEQ_PUSH: begin
          if (prot_fault || cnt == '0) begin
            state      <= SEQ_IDLE;
            busy       <= 1'b0;
            wr_valid   <= 1'b0;
            done       <= 1'b1;
            spu_valid  <= 1'b1;
            spu_sel    <= sel_q;
            spu_val    <= sp_q - FRAME;
            if (prot_fault) begin
              done_exc   <= EXC_W'(MEMM_ID);
              pend_valid <= 1'b1;
              pend_exc   <= exc_q;
              err_evt    <= 1'b1;
            end else begin
              done_exc <= exc_q;
            end
          end else begin
            cnt     <= cnt_nxt;
            wr_addr <= wr_addr - STEP;
            wr_data <= ctx_q[cnt_nxt*DATA_W +: DATA_W];
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R4
  addr_floor_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr >= lim_q));
  // R1
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !prot_fault && cnt != '0) |=> (wr_valid && wr_addr == $past(wr_addr) - STEP));
  // R5
  fault_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && prot_fault) |=> (!wr_valid && done && done_exc == EXC_W'(MEMM_ID) && pend_valid));
  // R6
  entry_after_push_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid);
  // R3
  ovf_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_IDLE && req && frame_ovf) |=> (!wr_valid && spu_val == $past(lim_act)));
endmodule

// File: rtl/stack_entry_engine.sv
module stack_entry_engine
  import ses_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int EXC_W       = 9,
  parameter int FRAME_WORDS = 8,
  parameter int WORD_BYTES  = 4,
  parameter int USAGE_ID    = 6,
  parameter int MEMM_ID     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          exc_req,
  input  logic [EXC_W-1:0]              exc_id,
  input  logic [FRAME_WORDS*DATA_W-1:0] ctx_frame,
  input  logic                          stack_sel,
  input  logic [ADDR_W-1:0]             msp,
  input  logic [ADDR_W-1:0]             psp,
  input  logic [ADDR_W-1:0]             msp_lim,
  input  logic [ADDR_W-1:0]             psp_lim,
  input  logic                          sp_wr_en,
  input  logic [ADDR_W-1:0]             sp_wr_val,
  input  logic                          mem_prot_fault,
  output logic                          mem_wr_valid,
  output logic [ADDR_W-1:0]             mem_wr_addr,
  output logic [DATA_W-1:0]             mem_wr_data,
  output logic                          stacking_busy,
  output logic                          entry_done,
  output logic [EXC_W-1:0]              entry_exc,
  output logic                          pend_valid,
  output logic [EXC_W-1:0]              pend_exc,
  output logic                          sp_upd_valid,
  output logic                          sp_upd_sel,
  output logic [ADDR_W-1:0]             sp_upd_val,
  output logic                          spw_ovf,
  input  logic [STAT_W-1:0]             stat_clr,
  output logic [STAT_W-1:0]             fault_stat
);
  localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;

  logic [ADDR_W-1:0] sp_act;
  logic [ADDR_W-1:0] lim_act;
  logic              frame_ovf;
  logic              spw_below;
  logic              ovf_evt;
  logic              err_evt;

  assign sp_act  = stack_sel ? psp     : msp;
  assign lim_act = stack_sel ? psp_lim : msp_lim;

  ses_limit_cmp #(.ADDR_W(ADDR_W), .OFFSET(FRAME_BYTES)) frame_cmp_i (
    .base (sp_act),
    .limit(lim_act),
    .below(frame_ovf)
  );

  ses_limit_cmp #(.ADDR_W(ADDR_W), .OFFSET(0)) spw_cmp_i (
    .base (sp_wr_val),
    .limit(lim_act),
    .below(spw_below)
  );

  ses_push_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXC_W(EXC_W), .FRAME_WORDS(FRAME_WORDS),
    .WORD_BYTES(WORD_BYTES), .USAGE_ID(USAGE_ID), .MEMM_ID(MEMM_ID)
  ) seq_i (
    .clk(clk), .rst(rst), .req(exc_req), .req_exc(exc_id), .req_sel(stack_sel),
    .sp_act(sp_act), .lim_act(lim_act), .frame_ovf(frame_ovf), .ctx(ctx_frame),
    .prot_fault(mem_prot_fault), .wr_valid(mem_wr_valid), .wr_addr(mem_wr_addr),
    .wr_data(mem_wr_data), .busy(stacking_busy), .done(entry_done), .done_exc(entry_exc),
    .pend_valid(pend_valid), .pend_exc(pend_exc), .spu_valid(sp_upd_valid),
    .spu_sel(sp_upd_sel), .spu_val(sp_upd_val), .ovf_evt(ovf_evt), .err_evt(err_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) spw_ovf <= 1'b0;
    else     spw_ovf <= sp_wr_en && !stacking_busy && spw_below;
  end

  ses_fault_status stat_i (
    .clk(clk), .rst(rst), .set_ovf(ovf_evt | spw_ovf), .set_err(err_evt),
    .clr(stat_clr), .stat(fault_stat)
  );

  // R8
  spw_ignored_busy_chk: assert property (@(posedge clk) disable iff (rst)
    stacking_busy |=> !spw_ovf);
  // R8
  spw_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (sp_wr_en && !stacking_busy && sp_wr_val < lim_act) |=> spw_ovf);
endmodule

// File: tb/stack_entry_engine_tb_top.sv
module stack_entry_engine_tb_top;
  localparam int USAGE = 6;
  localparam int MEMM  = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         exc_req = 1'b0;
  logic [8:0]   exc_id = '0;
  logic [255:0] ctx_frame = '0;
  logic         stack_sel = 1'b0;
  logic [31:0]  msp = '0, psp = '0, msp_lim = '0, psp_lim = '0;
  logic         sp_wr_en = 1'b0;
  logic [31:0]  sp_wr_val = '0;
  logic         mem_prot_fault = 1'b0;
  logic         mem_wr_valid, stacking_busy, entry_done, pend_valid;
  logic         sp_upd_valid, sp_upd_sel, spw_ovf;
  logic [31:0]  mem_wr_addr, mem_wr_data, sp_upd_val;
  logic [8:0]   entry_exc, pend_exc;
  logic [1:0]   stat_clr = '0;
  logic [1:0]   fault_stat;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  stack_entry_engine dut_i (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_id(exc_id), .ctx_frame(ctx_frame),
    .stack_sel(stack_sel), .msp(msp), .psp(psp), .msp_lim(msp_lim), .psp_lim(psp_lim),
    .sp_wr_en(sp_wr_en), .sp_wr_val(sp_wr_val), .mem_prot_fault(mem_prot_fault),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .stacking_busy(stacking_busy), .entry_done(entry_done), .entry_exc(entry_exc),
    .pend_valid(pend_valid), .pend_exc(pend_exc), .sp_upd_valid(sp_upd_valid),
    .sp_upd_sel(sp_upd_sel), .sp_upd_val(sp_upd_val), .spw_ovf(spw_ovf),
    .stat_clr(stat_clr), .fault_stat(fault_stat)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [31:0] word_of(input bit sel, input int i);
    return 32'hA5000000 | (32'(sel) << 16) | (32'(i) << 8) | 32'(i * 17);
  endfunction

  task automatic clear_stat();
    @(negedge clk); stat_clr = 2'b11;
    @(negedge clk); stat_clr = 2'b00;
    chk(fault_stat == 2'b00, "R9 clear", 64'(fault_stat), 0);
  endtask

  task automatic run_entry(input bit sel, input logic [31:0] sp, input logic [31:0] lim,
                           input int fk, input logic [8:0] id, input bit disturb);
    bit ovf;
    bit hit;
    @(negedge clk);
    for (int i = 0; i < 8; i++) ctx_frame[i*32 +: 32] = word_of(sel, i);
    if (sel) begin psp = sp; psp_lim = lim; msp = sp + 32'h40; msp_lim = lim + 32'h80; end
    else     begin msp = sp; msp_lim = lim; psp = sp + 32'h40; psp_lim = lim + 32'h80; end
    stack_sel = sel; exc_id = id; exc_req = 1'b1;
    @(negedge clk);
    exc_req = 1'b0;
    ovf = (sp < 32) || ((sp - 32) < lim);
    hit = 0;
    if (ovf) begin
      chk(entry_done && entry_exc == 9'(USAGE), "R3 overflow entry", 64'(entry_exc), USAGE);
      chk(!mem_wr_valid, "R3 no write", 64'(mem_wr_valid), 0);
      chk(sp_upd_valid && sp_upd_val == lim, "R3 sp clamp", 64'(sp_upd_val), 64'(lim));
      chk(sp_upd_sel == sel, "R2 stack echo", 64'(sp_upd_sel), 64'(sel));
      chk(pend_valid && pend_exc == id, "R7 pending", 64'(pend_exc), 64'(id));
      @(negedge clk);
      chk(fault_stat == 2'b01, "R9 overflow flag", 64'(fault_stat), 1);
      chk(!mem_wr_valid, "R4 no write later", 64'(mem_wr_valid), 0);
    end else begin
      for (int k = 0; k < 8; k++) begin
        if (!hit) begin
          chk(mem_wr_valid && stacking_busy, "R1 write valid", 64'(mem_wr_valid), 1);
          chk(mem_wr_addr == sp - 32'(4 * (k + 1)), "R1 address", 64'(mem_wr_addr),
              64'(sp - 32'(4 * (k + 1))));
          chk(mem_wr_data == word_of(sel, 7 - k), "R2 data", 64'(mem_wr_data),
              64'(word_of(sel, 7 - k)));
          chk(mem_wr_addr >= lim, "R4 floor", 64'(mem_wr_addr), 64'(lim));
          chk(!entry_done, "R6 no early entry", 64'(entry_done), 0);
          if (disturb && k == 2) begin sp_wr_en = 1'b1; sp_wr_val = 32'h0; end
          if (disturb && k == 3) begin
            chk(!spw_ovf, "R8 ignored while busy", 64'(spw_ovf), 0);
            exc_req = 1'b1; exc_id = 9'h1F;
          end
          if (k == fk) begin
            mem_prot_fault = 1'b1;
            @(negedge clk);
            mem_prot_fault = 1'b0;
            chk(entry_done && entry_exc == 9'(MEMM), "R5 memmanage entry", 64'(entry_exc), MEMM);
            chk(!mem_wr_valid, "R5 abandon", 64'(mem_wr_valid), 0);
            chk(sp_upd_val == sp - 32, "R5 sp", 64'(sp_upd_val), 64'(sp - 32));
            chk(pend_valid && pend_exc == id, "R7 pending", 64'(pend_exc), 64'(id));
            @(negedge clk);
            chk(!mem_wr_valid, "R5 no later write", 64'(mem_wr_valid), 0);
            chk(fault_stat == 2'b10, "R9 stacking error flag", 64'(fault_stat), 2);
            hit = 1;
          end else begin
            @(negedge clk);
            sp_wr_en = 1'b0; exc_req = 1'b0;
          end
        end
      end
      if (!hit) begin
        chk(entry_done && entry_exc == id, "R6 normal entry", 64'(entry_exc), 64'(id));
        chk(!pend_valid, "R7 no pending", 64'(pend_valid), 0);
        chk(sp_upd_valid && sp_upd_val == sp - 32, "R6 sp", 64'(sp_upd_val), 64'(sp - 32));
        chk(sp_upd_sel == sel, "R2 stack echo", 64'(sp_upd_sel), 64'(sel));
        chk(!mem_wr_valid, "R6 writes end", 64'(mem_wr_valid), 0);
        @(negedge clk);
        chk(!mem_wr_valid && !entry_done, "R6 busy request ignored", 64'(mem_wr_valid), 0);
        chk(fault_stat == 2'b00, "R9 no flag", 64'(fault_stat), 0);
      end
    end
    clear_stat();
  endtask

  task automatic sp_write(input bit sel, input logic [31:0] lim, input logic [31:0] val);
    bit below;
    @(negedge clk);
    stack_sel = sel;
    if (sel) begin psp_lim = lim; msp_lim = 32'h0; end
    else     begin msp_lim = lim; psp_lim = 32'h0; end
    sp_wr_en = 1'b1; sp_wr_val = val;
    @(negedge clk);
    sp_wr_en = 1'b0;
    below = val < lim;
    chk(spw_ovf == below, "R8 write flag", 64'(spw_ovf), 64'(below));
    if (below) stat_clr = 2'b01;
    @(negedge clk);
    stat_clr = 2'b00;
    chk(fault_stat[0] == below, "R9 set over clear", 64'(fault_stat), 64'(below));
    clear_stat();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!mem_wr_valid && !entry_done && !pend_valid && !sp_upd_valid && !spw_ovf &&
        !stacking_busy && fault_stat == 2'b00 && mem_wr_addr == '0 && sp_upd_val == '0,
        "R10 reset", 64'(fault_stat), 0);
    for (int s = 0; s < 2; s++) begin
      for (int d = 5; d <= 11; d++)
        run_entry(s[0], 32'h2000_0100 + 32'(4 * d), 32'h2000_0100, -1, 9'(16 + d), 1'b0);
      run_entry(s[0], 32'h10, 32'h0, -1, 9'h20, 1'b0);
      for (int f = 0; f < 8; f++)
        run_entry(s[0], 32'h3000_0040, 32'h3000_0000, f, 9'(40 + f), 1'b0);
      run_entry(s[0], 32'h3000_0080, 32'h3000_0000, -1, 9'h33, 1'b1);
      for (int v = -3; v <= 3; v++)
        sp_write(s[0], 32'h2000_0100, 32'h2000_0100 + 32'(4 * v));
    end
    finish_run();
  end
endmodule